// File: doc/BRIEF.md
# Masked Fault Interrupt Aggregator

This block gathers eight fault and event levels from protection monitors into a sticky status register. It raises an interrupt request to a host processor whenever a latched bit is not masked. The request leaves the block as an active-high pull-down enable, so the pin is either driven low or left at high impedance. The host reads the status register with a one-cycle strobe. The read clears every latched bit. A condition that is still present after the read latches again once a fixed recheck window has elapsed, so a persistent fault keeps pulling the pin low.

The two supply-voltage warnings, undervoltage lockout and low battery, pass through a deglitch filter before they reach the status register. The filtered levels are also brought out for downstream use. The eight-bit mask register is written through a plain write port. It gates only the pin: a masked event still sets its status bit. The fault inputs are already digital and synchronous to the clock. All control and status pins are plain levels or strobes, since the block carries no data stream.

Top module: `fault_irq_agg`

## Requirements
- R1: Status bit positions, from bit 7 down to bit 0, are: LED-rail overvoltage, 6 V rail power-good fault, power-on pin deasserted, display regulator fault, undervoltage lockout, low battery, thermal shutdown, thermal warning. On an unfiltered input (bits 7..4, 1, 0), a rising level sets its status bit at the second clock edge after the input changes.
- R2: `irq_pull` is 1 exactly when some status bit is 1 and the mask bit at the same position is 0. Otherwise it is 0, which means high impedance.
- R3: A cycle with `stat_rd` high clears all status bits at that edge, and `irq_pull` falls with them.
- R4: If a fault level is still high after a clearing read, its bit sets again exactly `RECHECK_CYC` edges after the read. A level that has gone low does not set its bit again.
- R5: A set mask bit keeps its event from raising `irq_pull`, but the event still sets its status bit. Writing the mask leaves the status bits unchanged.
- R6: After reset the status register is 0x00, the mask is 0x00 (all sources unmasked), `irq_pull` is 0 and both filtered outputs are 0.
- R7: Bits 3 and 2 use filtered levels. A filtered level changes only after the input has held its new value for `DEGLITCH_CYC` consecutive sampled cycles, and a shorter pulse has no effect on the filtered output or the status register.
- R8: An input edge that falls in the same cycle as a clearing read is not lost: its bit is set after that read.
- R9: A latched bit stays set after its input level drops, until a read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fault_lvl | input | 8 | Raw fault and event levels, in the bit order of R1 |
| stat_rd | input | 1 | Status read strobe; clears the status register |
| mask_we | input | 1 | Mask write enable |
| mask_wdata | input | 8 | Mask write data; a 1 masks that source |
| stat_rdata | output | 8 | Current status register contents |
| irq_pull | output | 1 | 1 = drive the interrupt pin low, 0 = high impedance |
| uv_warn_filt | output | 1 | Deglitched undervoltage level |
| batlow_warn_filt | output | 1 | Deglitched low-battery level |

## Verification
The result latencies are as follows:
- An unfiltered fault shows in `stat_rdata` two edges after the input changes: one edge for the input register and one for the latch.
- `irq_pull` and the cleared status follow a read or a mask write at the very next edge, because the pin is decoded combinationally from registers.
- A filtered level moves `DEGLITCH_CYC`+1 edges after its input changes, and its status bit follows one edge later.
- A persistent fault re-latches exactly `RECHECK_CYC` edges after the read.

The bench drives inputs 1 ns after a rising edge and samples in that same slot. It counts edges with explicit tick loops, and it checks each result both one edge before its due edge and at the due edge.

// File: rtl/fia_pkg.sv
package fia_pkg;
  localparam int unsigned SRC_W = 8;

  // bit positions of the status register
  localparam int unsigned IDX_HOT     = 0;
  localparam int unsigned IDX_TSD     = 1;
  localparam int unsigned IDX_BATLOW  = 2;
  localparam int unsigned IDX_UVLO    = 3;
  localparam int unsigned IDX_DISPREG = 4;
  localparam int unsigned IDX_PWRON   = 5;
  localparam int unsigned IDX_PG6V    = 6;
  localparam int unsigned IDX_LEDOVP  = 7;

  // sources that are deglitched before latching
  localparam logic [SRC_W-1:0] FILT_SEL =
    (SRC_W'(1) << IDX_UVLO) | (SRC_W'(1) << IDX_BATLOW);

  typedef logic [SRC_W-1:0] src_vec_t;
endpackage

// File: rtl/fia_deglitch.sv
module fia_deglitch #(
  parameter int unsigned CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int unsigned CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (din == out_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      out_q <= din;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign dout = out_q;
endmodule

// File: rtl/fia_recheck_timer.sv
module fia_recheck_timer #(
  parameter int unsigned CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic fire
);
  localparam int unsigned CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (start)        cnt_q <= LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  // one-cycle pulse on the last count; a new read restarts the window
  assign fire = (cnt_q == CW'(1)) && !start;
endmodule

// File: rtl/fia_status_latch.sv
module fia_status_latch
  import fia_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     recheck,
  input  src_vec_t qual,
  output src_vec_t status
);
  src_vec_t prev_q, stat_q, rise, relatch, stat_d;

  assign rise    = qual & ~prev_q;
  assign relatch = recheck ? qual : '0;
  // a clear wipes old bits only; new edges in the same cycle survive
  assign stat_d  = (clr ? '0 : stat_q) | rise | relatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= qual;
      stat_q <= stat_d;
    end
  end

  assign status = stat_q;
endmodule

// File: rtl/fault_irq_agg.sv
module fault_irq_agg
  import fia_pkg::*;
#(
  parameter int unsigned DEGLITCH_CYC = 6,
  parameter int unsigned RECHECK_CYC  = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] fault_lvl,
  input  logic       stat_rd,
  input  logic       mask_we,
  input  logic [7:0] mask_wdata,
  output logic [7:0] stat_rdata,
  output logic       irq_pull,
  output logic       uv_warn_filt,
  output logic       batlow_warn_filt
);
  src_vec_t sync_q;
  src_vec_t qual;
  src_vec_t mask_q;
  src_vec_t status;
  logic     recheck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= fault_lvl;
  end

  for (genvar i = 0; i < SRC_W; i++) begin : g_src
    if (FILT_SEL[i]) begin : g_filt
      fia_deglitch #(.CYC(DEGLITCH_CYC)) dg_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sync_q[i]),
        .dout (qual[i])
      );
    end else begin : g_pass
      assign qual[i] = sync_q[i];
    end
  end

  fia_recheck_timer #(.CYC(RECHECK_CYC)) tmr_i (
    .clk  (clk),
    .rst_n(rst_n),
    .start(stat_rd),
    .fire (recheck)
  );

  fia_status_latch lat_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (stat_rd),
    .recheck(recheck),
    .qual   (qual),
    .status (status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;
  end

  assign stat_rdata       = status;
  assign irq_pull         = |(status & ~mask_q);
  assign uv_warn_filt     = qual[IDX_UVLO];
  assign batlow_warn_filt = qual[IDX_BATLOW];
endmodule

// File: rtl/fia_chk.sv
module fia_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stat_rd,
  input logic       mask_we,
  input logic [7:0] stat_rdata,
  input logic       irq_pull,
  input logic [7:0] qual,
  input logic [7:0] sync_q
);
  // R2
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pull |-> (stat_rdata != 8'h00));

  // R3
  clr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> ((stat_rdata & ~$past(qual)) == 8'h00));

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> (($past(stat_rdata) & ~stat_rdata) == 8'h00));

  // R5
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && !stat_rd) |=> (($past(stat_rdata) & ~stat_rdata) == 8'h00));

  // R7
  uv_filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qual[3] != $past(qual[3])) |-> (qual[3] == $past(sync_q[3])));

  // R7
  bat_filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qual[2] != $past(qual[2])) |-> (qual[2] == $past(sync_q[2])));
endmodule

bind fault_irq_agg fia_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .stat_rd   (stat_rd),
  .mask_we   (mask_we),
  .stat_rdata(stat_rdata),
  .irq_pull  (irq_pull),
  .qual      (qual),
  .sync_q    (sync_q)
);

// File: tb/fault_irq_agg_tb_top.sv
module fault_irq_agg_tb_top;
  localparam int unsigned DG = 6;
  localparam int unsigned RC = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] flt = '0;
  logic       rd = 1'b0;
  logic       mwe = 1'b0;
  logic [7:0] mwd = '0;
  logic [7:0] stat;
  logic       irq, uvf, blf;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  fault_irq_agg #(.DEGLITCH_CYC(DG), .RECHECK_CYC(RC)) dut_i (
    .clk(clk), .rst_n(rst_n), .fault_lvl(flt), .stat_rd(rd),
    .mask_we(mwe), .mask_wdata(mwd), .stat_rdata(stat),
    .irq_pull(irq), .uv_warn_filt(uvf), .batlow_warn_filt(blf)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    flt = '0;
    repeat (DG + 3) tick();
    rd = 1'b1;
    tick();
    rd = 1'b0;
    repeat (RC + 2) tick();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R6 reset state
    check("R6 status", stat, 8'h00);
    check("R6 irq", {7'b0, irq}, 8'h00);
    check("R6 filters", {6'b0, uvf, blf}, 8'h00);

    // R1 R2 R3 R9 sweep over unfiltered sources
    for (int i = 0; i < 8; i++) begin
      if (i == 2 || i == 3) continue;
      flt = 8'(1 << i);
      tick(); tick();
      check("R1 bit position", stat, 8'(1 << i));
      check("R2 R6 irq unmasked", {7'b0, irq}, 8'h01);
      flt = '0;
      tick();
      check("R9 sticky", stat, 8'(1 << i));
      rd = 1'b1;
      tick();
      rd = 1'b0;
      check("R3 cleared", stat, 8'h00);
      check("R3 irq released", {7'b0, irq}, 8'h00);
      repeat (RC + 2) tick();
      check("R4 no relatch when gone", stat, 8'h00);
    end

    // R4 persistent fault
    flt = 8'h02;
    tick(); tick();
    rd = 1'b1;
    tick();
    rd = 1'b0;
    check("R4 cleared by read", stat, 8'h00);
    repeat (RC - 1) tick();
    check("R4 not before window", stat, 8'h00);
    tick();
    check("R4 relatched", stat, 8'h02);
    check("R4 irq again", {7'b0, irq}, 8'h01);
    clear_all();

    // R5 all masked
    mwd = 8'hFF; mwe = 1'b1;
    tick();
    mwe = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i == 2 || i == 3) continue;
      flt = 8'(1 << i);
      tick(); tick();
      check("R5 masked still latches", stat, 8'(1 << i));
      check("R5 masked no irq", {7'b0, irq}, 8'h00);
      flt = '0;
      tick();
      rd = 1'b1;
      tick();
      rd = 1'b0;
    end
    repeat (RC + 2) tick();

    // R2 exhaustive mask sweep over a fixed status pattern
    flt = 8'hF3;
    tick(); tick();
    flt = '0;
    tick();
    check("R1 multi latch", stat, 8'hF3);
    for (int m = 0; m < 256; m++) begin
      mwd = 8'(m); mwe = 1'b1;
      tick();
      mwe = 1'b0;
      check("R2 mask sweep irq", {7'b0, irq}, {7'b0, |(8'hF3 & ~8'(m))});
      check("R5 mask keeps status", stat, 8'hF3);
    end
    mwd = 8'h00; mwe = 1'b1;
    tick();
    mwe = 1'b0;
    clear_all();

    // R7 deglitch on bits 3 and 2
    for (int k = 0; k < 2; k++) begin
      automatic int b = (k == 0) ? 3 : 2;
      flt = 8'(1 << b);
      repeat (DG - 1) tick();
      flt = '0;
      repeat (DG + 3) tick();
      check("R7 short pulse filter", {6'b0, uvf, blf}, 8'h00);
      check("R7 short pulse status", stat, 8'h00);
      flt = 8'(1 << b);
      repeat (DG) tick();
      check("R7 not yet filtered", {6'b0, uvf, blf}, 8'h00);
      tick();
      check("R7 filter set", {6'b0, uvf, blf}, (b == 3) ? 8'h02 : 8'h01);
      tick();
      check("R7 status set", stat, 8'(1 << b));
      check("R7 irq", {7'b0, irq}, 8'h01);
      clear_all();
      check("R7 filter released", {6'b0, uvf, blf}, 8'h00);
      check("R7 cleared", stat, 8'h00);
    end

    // R8 edge during clearing read
    flt = 8'h80;
    tick(); tick();
    flt = 8'h00;
    tick();
    flt = 8'h01;
    tick();
    rd = 1'b1;
    tick();
    rd = 1'b0;
    check("R8 edge kept over read", stat, 8'h01);
    check("R8 irq", {7'b0, irq}, 8'h01);
    clear_all();
    check("R3 final clear", stat, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule